// File: doc/BRIEF.md
# Bus Address Hold Controller

This block sits in the bus interface of a processor and decides, cycle by cycle, whether the address bus is driven and whether a new bus cycle may begin. An external bus master raises an active-high hold request when it wants the address pins for a snoop invalidation. From the next clock edge on, the controller stops driving the address. No new cycle is allowed to start while the request is high. Data and ready traffic for a cycle that is already open carry on as normal, so that cycle can still finish during the hold.

No acknowledge is produced, because the release always takes effect on the next edge. The address of each cycle is captured when the cycle starts. If the hold ends while that cycle is still open, the captured address goes back onto the bus unchanged. If a ready closed the cycle during the hold, nothing is driven after the hold, and a waiting request starts on the first clock with the hold low. A requester keeps its request line high until the start strobe accepts it. The hold request is honoured while reset is asserted as well, and during reset the bus stays released.

Top module: `addr_hold_ctrl`

## Requirements
- R1: While rst_ni is low, addr_oe_o, cyc_start_o and cyc_busy_o are all 0, whatever hold_req_i is.
- R2: If hold_req_i is 1 at a rising clock edge, addr_oe_o is 0 for the whole clock period that follows that edge.
- R3: While hold_req_i is 1, cyc_start_o is 0 in the same cycle.
- R4: When cyc_start_o is 1 at an edge, cyc_busy_o is 1 after that edge, and addr_o then equals the req_addr_i sampled at that edge.
- R5: When cyc_busy_o and rdy_i are both 1 at an edge, cyc_busy_o is 0 after that edge. This applies whether or not a hold is in force.
- R6: While a cycle stays open, addr_o keeps the captured address whatever req_addr_i does. After the hold is removed, addr_oe_o is 1 again from the next edge, carrying that same address.
- R7: addr_oe_o is 1 only while a cycle is open. If a ready ends the cycle during a hold, no address is driven after the hold.
- R8: A request held high during a hold gives cyc_start_o = 1 in the first cycle in which hold_req_i is 0, provided no cycle is open.
- R9: cyc_start_o is never 1 while cyc_busy_o is 1, so at most one cycle is open at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| hold_req_i | input | 1 | Active-high address hold request from another master |
| rdy_i | input | 1 | Ready that closes the open bus cycle |
| req_i | input | 1 | New cycle request, held high until accepted |
| req_addr_i | input | ADDR_W | Address of the requested cycle |
| addr_oe_o | output | 1 | Address bus drive enable |
| addr_o | output | ADDR_W | Captured address of the open cycle |
| cyc_start_o | output | 1 | Cycle start strobe; also acts as the acceptance of req_i |
| cyc_busy_o | output | 1 | A bus cycle is open |

## Verification
The bench builds the block with ADDR_W = 16, which keeps the random addresses easy to read. Any change of the captured address during a hold stands out against the freely changing req_addr_i. Random hold, ready and request patterns place a ready inside a hold, a hold on the same edge as a start, and a request arriving mid-hold. Resets are applied with the hold both high and low.

// File: rtl/ahc_pkg.sv
package ahc_pkg;
  typedef enum logic {
    CYC_IDLE = 1'b0,
    CYC_OPEN = 1'b1
  } cyc_state_e;
endpackage

// File: rtl/ahc_hold_stage.sv
module ahc_hold_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_req_i,
  output logic released_o
);
  logic rel_d, rel_q;

  // reset keeps the bus released; afterwards follow the request each edge
  always_comb begin
    rel_d = hold_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_q <= 1'b1;
    else         rel_q <= rel_d;
  end

  assign released_o = rel_q;
endmodule

// File: rtl/ahc_cycle_track.sv
module ahc_cycle_track #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rdy_i,
  input  logic [ADDR_W-1:0] addr_in_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o
);
  import ahc_pkg::*;

  cyc_state_e        st_d, st_q;
  logic [ADDR_W-1:0] adr_d, adr_q;
  logic              adr_en;

  always_comb begin
    st_d   = st_q;
    adr_en = 1'b0;
    unique case (st_q)
      CYC_IDLE: if (start_i) begin
        st_d   = CYC_OPEN;
        adr_en = 1'b1;
      end
      CYC_OPEN: if (rdy_i) st_d = CYC_IDLE;
      default:  st_d = CYC_IDLE;
    endcase
    adr_d = adr_en ? addr_in_i : adr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CYC_IDLE;
      adr_q <= '0;
    end else begin
      st_q  <= st_d;
      adr_q <= adr_d;
    end
  end

  assign busy_o = (st_q == CYC_OPEN);
  assign addr_o = adr_q;

  // ready closes the open cycle regardless of any hold
  assert_rdy_closes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && rdy_i) |=> !busy_o);

  // captured address does not move while the cycle stays open
  assert_addr_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));
endmodule

// File: rtl/ahc_issue_gate.sv
module ahc_issue_gate (
  input  logic rst_ni,
  input  logic hold_req_i,
  input  logic req_i,
  input  logic busy_i,
  output logic start_o
);
  logic may_issue;

  always_comb begin
    may_issue = rst_ni && !hold_req_i && !busy_i;
    start_o   = may_issue && req_i;
  end
endmodule

// File: rtl/addr_hold_ctrl.sv
module addr_hold_ctrl #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_req_i,
  input  logic              rdy_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              addr_oe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cyc_start_o,
  output logic              cyc_busy_o
);
  logic released;
  logic busy;
  logic start;

  ahc_hold_stage u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_req_i (hold_req_i),
    .released_o (released)
  );

  ahc_issue_gate u_gate (
    .rst_ni     (rst_ni),
    .hold_req_i (hold_req_i),
    .req_i      (req_i),
    .busy_i     (busy),
    .start_o    (start)
  );

  ahc_cycle_track #(.ADDR_W(ADDR_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rdy_i     (rdy_i),
    .addr_in_i (req_addr_i),
    .busy_o    (busy),
    .addr_o    (addr_o)
  );

  assign addr_oe_o   = busy && !released;
  assign cyc_start_o = start;
  assign cyc_busy_o  = busy;

  assert_release_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_req_i |=> !addr_oe_o);

  assert_no_start_in_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_req_i |-> !cyc_start_o);

  assert_start_captures_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> (cyc_busy_o && addr_o == $past(req_addr_i)));

  assert_redrive_after_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold_req_i) && !hold_req_i && cyc_busy_o && !rdy_i) |=> addr_oe_o);

  assert_drive_only_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_oe_o |-> cyc_busy_o);

  assert_queued_issue_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold_req_i) && !hold_req_i && req_i && !cyc_busy_o) |-> cyc_start_o);

  assert_single_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_busy_o |-> !cyc_start_o);
endmodule

// File: tb/addr_hold_ctrl_tb_top.sv
module addr_hold_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          hold_req_i;
  logic          rdy_i;
  logic          req_i;
  logic [AW-1:0] req_addr_i;
  logic          addr_oe_o;
  logic [AW-1:0] addr_o;
  logic          cyc_start_o;
  logic          cyc_busy_o;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic          m_busy, m_rel, m_just;
  logic [AW-1:0] m_addr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  addr_hold_ctrl #(.ADDR_W(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_req_i(hold_req_i), .rdy_i(rdy_i),
    .req_i(req_i), .req_addr_i(req_addr_i), .addr_oe_o(addr_oe_o),
    .addr_o(addr_o), .cyc_start_o(cyc_start_o), .cyc_busy_o(cyc_busy_o)
  );

  function automatic logic exp_start();
    return rst_ni && !m_busy && req_i && !hold_req_i;
  endfunction

  function automatic logic exp_oe();
    return rst_ni && m_busy && !m_rel;
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic rst, logic hold, logic req, logic rdy, logic [AW-1:0] a);
    logic st;
    @(negedge clk_i);
    rst_ni = rst; hold_req_i = hold; req_i = req; rdy_i = rdy; req_addr_i = a;
    if (!rst) begin m_busy = 1'b0; m_rel = 1'b1; m_addr = '0; m_just = 1'b0; end
    #1;
    st = exp_start();
    if (!rst) begin
      check("R1", {{(AW-3){1'b0}}, addr_oe_o, cyc_start_o, cyc_busy_o}, '0);
    end else begin
      check(hold ? "R3" : (m_busy ? "R9" : "R8"), {{(AW-1){1'b0}}, cyc_start_o}, {{(AW-1){1'b0}}, st});
      check(m_rel ? "R2" : (m_busy ? "R6" : "R7"), {{(AW-1){1'b0}}, addr_oe_o}, {{(AW-1){1'b0}}, exp_oe()});
      check("R5", {{(AW-1){1'b0}}, cyc_busy_o}, {{(AW-1){1'b0}}, m_busy});
      if (m_busy) check(m_just ? "R4" : "R6", addr_o, m_addr);
    end
    @(posedge clk_i);
    if (rst) begin
      m_rel  = hold;
      m_just = st;
      if (st) begin m_busy = 1'b1; m_addr = a; end
      else if (m_busy && rdy) m_busy = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_ni = 1'b0; hold_req_i = 1'b1; req_i = 1'b1; rdy_i = 1'b0; req_addr_i = '0;
    m_busy = 1'b0; m_rel = 1'b1; m_addr = '0; m_just = 1'b0;
    // R1: reset with hold high and low
    step(0, 1, 1, 0, 16'h1111);
    step(0, 0, 1, 0, 16'h2222);
    step(0, 1, 0, 0, 16'h3333);
    // R4, R6: start then hold, address moves, hold ends, same address returns
    step(1, 0, 1, 0, 16'hA5A5);
    step(1, 0, 0, 0, 16'h0000);
    step(1, 1, 1, 0, 16'hFFFF);
    step(1, 1, 1, 0, 16'h1234);
    step(1, 0, 0, 0, 16'h4321);
    step(1, 0, 0, 0, 16'h0F0F);
    step(1, 0, 0, 1, 16'h0F0F);
    // R7, R5: ready inside a hold, no redrive after it
    step(1, 0, 1, 0, 16'hBEEF);
    step(1, 1, 0, 0, 16'h0000);
    step(1, 1, 0, 1, 16'h0000);
    step(1, 1, 0, 0, 16'h0000);
    step(1, 0, 0, 0, 16'h0000);
    step(1, 0, 0, 0, 16'h0000);
    // R8, R3: request held through a hold starts on first clear cycle
    step(1, 1, 1, 0, 16'hC0DE);
    step(1, 1, 1, 0, 16'hC0DE);
    step(1, 0, 1, 0, 16'hC0DE);
    step(1, 0, 0, 1, 16'h0000);
    // R9 and the rest: random mix, occasional reset
    for (int i = 0; i < 3000; i++) begin
      logic r, h, q, y;
      r = ($urandom_range(0, 199) != 0);
      h = ($urandom_range(0, 3) == 0);
      q = ($urandom_range(0, 2) != 0);
      y = ($urandom_range(0, 2) == 0);
      step(r, h, q, y, AW'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule